// File: doc/BRIEF.md
# Loop-Nest Microcode Sequencer

This block walks a nest of up to six counted loops and keeps four working registers that an address generator reads as indices and memory offsets. The loop bounds and the strides live in sixteen read-only values. Each loop level owns a short run of 8-bit micro-instructions. Each one is either a move or an add into one of the working registers. The block runs that code whenever its level is the one being stepped.

A one-byte descriptor per level names the read-only value that holds its iteration count, and says how many micro-instructions belong to it. The code for level k starts right after the code of all levels below it. Each pulse on `step` advances the nest by one iteration. The block resets the inner counters that wrapped and runs the stepped level's code at one instruction per cycle while `busy_o` is high. When `busy_o` falls, the working registers, the loop counters and the wrap mask hold the result of that step. The program and the read-only values are plain inputs and are held steady during a run. A pulse on `start` returns the nest to its first iteration.

Top module: `loopseq_top`

## Requirements
- R1: After reset, and in the cycle after `start` is high, every working register and every loop counter reads zero, and `wrap_o`, `busy_o` and `done_o` are low.
- R2: A micro-instruction byte is decoded as follows. Bit 7 is the operation (1 = add, 0 = move). Bits 6:5 select the destination working register. Bit 4 selects the source kind (1 = read-only value, 0 = working register). Bits 3:0 index the source; only bits 1:0 are used for a working register. A move copies the source into the destination. An add writes destination + source, modulo 2^DATA_W.
- R3: Descriptor k sits in bits 8k+7:8k of `loop_desc_i`, and level 0 is the innermost. Its bits 3:0 pick the read-only value that gives the iteration count, where a count of 0 acts as 1. Its bits 7:4 give the number of micro-instructions. The code of level k starts at the sum of the counts of levels 0..k-1. Slot i sits in bits 8i+7:8i of `code_i`, and a slot at or beyond CODE_LEN executes as a no-op.
- R4: An accepted step selects the innermost level whose counter is below its count minus one. It increments that counter, clears every counter below it, and sets `wrap_o` bit j for each cleared level j (all other bits clear). The level's micro-instructions then run in slot order, one per cycle, with `busy_o` high exactly while they run. Working registers do not change while `busy_o` is low.
- R5: A step taken while every level is on its last iteration clears all counters, sets every `wrap_o` bit, raises `done_o`, and runs no micro-instruction.
- R6: `done_o` stays high until `start`. Steps while it is high change no register, counter or wrap bit.
- R7: A step requested while `busy_o` is high is ignored.
- R8: Stepping a level whose instruction count is zero updates the counters and `wrap_o` as in R4, and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Returns the nest to its first iteration |
| step | input | 1 | Request to advance one iteration |
| code_i | input | CODE_LEN*8 | Micro-instruction slots |
| loop_desc_i | input | NUM_LOOPS*8 | Per-level descriptors |
| ro_i | input | 16*DATA_W | Read-only values (bounds, strides) |
| rw_o | output | 4*DATA_W | Working registers, register r at bits r*DATA_W |
| iter_o | output | NUM_LOOPS*DATA_W | Loop counters, level k at bits k*DATA_W |
| wrap_o | output | NUM_LOOPS | Levels that wrapped on the last accepted step |
| busy_o | output | 1 | Micro-instructions of a step are running |
| done_o | output | 1 | The outermost level has wrapped |

## Verification
The bench runs two programs through every iteration of their nests and checks each step against an arithmetic model of the loops. The programs contain a level with a count-zero range, a level with an empty code run, and code that runs past the last slot. A design that used an empty range literally would stall or skip that level. One that mis-summed code bases would run the wrong slots. One that did not treat slots past the end as no-ops would write stray values. The bench also checks chained adds that overflow, and adds whose source is the destination itself. Extra step pulses are sent in mid-run and after the final wrap; a design that accepted them would skip iterations or restart the nest.

// File: rtl/loopseq_pkg.sv
package loopseq_pkg;
    localparam int UOP_W  = 8;
    localparam int DESC_W = 8;
    localparam int NUM_RW = 4;
    localparam int NUM_RO = 16;

    typedef enum logic {
        OP_MV  = 1'b0,
        OP_ADD = 1'b1
    } uop_kind_e;

    typedef struct packed {
        uop_kind_e  kind;
        logic [1:0] dst;
        logic       from_ro;
        logic [3:0] src;
    } uop_t;

    typedef struct packed {
        logic [3:0] n_uops;
        logic [3:0] range_sel;
    } loop_desc_t;

    function automatic uop_t decode_uop(input logic [UOP_W-1:0] b);
        return uop_t'(b);
    endfunction
endpackage

// File: rtl/loopseq_iter.sv
module loopseq_iter #(
    parameter int NUM_LOOPS = 6,
    parameter int DATA_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        advance,
    input  logic [NUM_LOOPS*DATA_W-1:0] range_flat,
    output logic [NUM_LOOPS-1:0]        sel_oh,
    output logic                        sel_found,
    output logic [NUM_LOOPS*DATA_W-1:0] cnt_flat
);
    logic [NUM_LOOPS-1:0] room;
    logic [NUM_LOOPS-1:0] below;

    assign sel_oh    = room & (~room + NUM_LOOPS'(1));
    assign below     = sel_oh - NUM_LOOPS'(1);
    assign sel_found = |room;

    for (genvar k = 0; k < NUM_LOOPS; k++) begin : g_lvl
        logic [DATA_W-1:0] rng;
        logic [DATA_W-1:0] cnt;
        logic [DATA_W:0]   nxt;

        assign rng     = range_flat[k*DATA_W +: DATA_W];
        assign nxt     = {1'b0, cnt} + (DATA_W+1)'(1);
        assign room[k] = (rng != '0) && (nxt < {1'b0, rng});
        assign cnt_flat[k*DATA_W +: DATA_W] = cnt;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                cnt <= '0;
            end else if (advance) begin
                if (sel_oh[k])
                    cnt <= cnt + DATA_W'(1);
                else if (below[k] || !sel_found)
                    cnt <= '0;
            end
        end

        // R3: a counter never leaves the range of its level after a step
        assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
            advance && !clr |=> (cnt == '0) || (cnt < rng));
    end
endmodule

// File: rtl/loopseq_exec.sv
module loopseq_exec
    import loopseq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CODE_LEN = 22,
    parameter int PC_W     = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     load,
    input  logic [PC_W-1:0]          load_pc,
    input  logic [3:0]               load_n,
    input  logic [CODE_LEN*UOP_W-1:0] code_flat,
    input  logic [NUM_RO*DATA_W-1:0] ro_flat,
    output logic                     busy,
    output logic [NUM_RW*DATA_W-1:0] rw_flat
);
    logic [PC_W-1:0]   pc;
    logic [3:0]        left;
    logic [UOP_W-1:0]  raw;
    uop_t              u;
    logic [DATA_W-1:0] rw [NUM_RW];
    logic [DATA_W-1:0] src_val;
    logic [DATA_W-1:0] res;

    always_comb begin
        raw = '0;
        for (int i = 0; i < CODE_LEN; i++)
            if (pc == PC_W'(i)) raw = code_flat[i*UOP_W +: UOP_W];
    end

    assign u       = decode_uop(raw);
    assign src_val = u.from_ro ? ro_flat[u.src*DATA_W +: DATA_W] : rw[u.src[1:0]];
    assign res     = (u.kind == OP_ADD) ? rw[u.dst] + src_val : src_val;
    assign busy    = (left != 4'd0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pc   <= '0;
            left <= 4'd0;
            for (int r = 0; r < NUM_RW; r++) rw[r] <= '0;
        end else if (load) begin
            pc   <= load_pc;
            left <= load_n;
        end else if (busy) begin
            rw[u.dst] <= res;
            pc        <= pc + PC_W'(1);
            left      <= left - 4'd1;
        end
    end

    for (genvar r = 0; r < NUM_RW; r++) begin : g_out
        assign rw_flat[r*DATA_W +: DATA_W] = rw[r];
    end

    // R4: working registers only change while code is running
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !busy && !clr |=> $stable(rw_flat));

    // R8: an empty code run never raises busy
    assert_zero_len_idle_R8: assert property (@(posedge clk) disable iff (rst)
        load && !clr && (load_n == 4'd0) |=> !busy);
endmodule

// File: rtl/loopseq_top.sv
module loopseq_top
    import loopseq_pkg::*;
#(
    parameter int NUM_LOOPS = 6,
    parameter int DATA_W    = 16,
    parameter int CODE_LEN  = 22
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic                          step,
    input  logic [CODE_LEN*8-1:0]         code_i,
    input  logic [NUM_LOOPS*8-1:0]        loop_desc_i,
    input  logic [16*DATA_W-1:0]          ro_i,
    output logic [4*DATA_W-1:0]           rw_o,
    output logic [NUM_LOOPS*DATA_W-1:0]   iter_o,
    output logic [NUM_LOOPS-1:0]          wrap_o,
    output logic                          busy_o,
    output logic                          done_o
);
    localparam int PC_W = $clog2(NUM_LOOPS * 15 + 1);

    logic [NUM_LOOPS*DATA_W-1:0] range_flat;
    logic [3:0]                  n_uops [NUM_LOOPS];
    logic [NUM_LOOPS-1:0]        sel_oh;
    logic                        sel_found;
    logic                        accept;
    logic [PC_W-1:0]             base;
    logic [3:0]                  run_n;
    logic [NUM_LOOPS-1:0]        wrap_mask;

    for (genvar k = 0; k < NUM_LOOPS; k++) begin : g_desc
        loop_desc_t d;
        assign d         = loop_desc_t'(loop_desc_i[k*DESC_W +: DESC_W]);
        assign n_uops[k] = d.n_uops;
        assign range_flat[k*DATA_W +: DATA_W] = ro_i[d.range_sel*DATA_W +: DATA_W];
    end

    always_comb begin
        base  = '0;
        run_n = 4'd0;
        for (int k = 0; k < NUM_LOOPS; k++) begin
            if (wrap_mask[k] && sel_found) base = base + PC_W'(n_uops[k]);
            if (sel_oh[k]) run_n = run_n | n_uops[k];
        end
    end

    assign accept    = step && !busy_o && !done_o && !start;
    assign wrap_mask = sel_found ? (sel_oh - NUM_LOOPS'(1)) : '1;

    loopseq_iter #(.NUM_LOOPS(NUM_LOOPS), .DATA_W(DATA_W)) u_iter (
        .clk        (clk),
        .rst        (rst),
        .clr        (start),
        .advance    (accept),
        .range_flat (range_flat),
        .sel_oh     (sel_oh),
        .sel_found  (sel_found),
        .cnt_flat   (iter_o)
    );

    loopseq_exec #(.DATA_W(DATA_W), .CODE_LEN(CODE_LEN), .PC_W(PC_W)) u_exec (
        .clk       (clk),
        .rst       (rst),
        .clr       (start),
        .load      (accept && sel_found),
        .load_pc   (base),
        .load_n    (run_n),
        .code_flat (code_i),
        .ro_flat   (ro_i),
        .busy      (busy_o),
        .rw_flat   (rw_o)
    );

    always_ff @(posedge clk) begin
        if (rst || start) begin
            wrap_o <= '0;
            done_o <= 1'b0;
        end else if (accept) begin
            wrap_o <= wrap_mask;
            if (!sel_found) done_o <= 1'b1;
        end
    end

    // R4: wrapped levels always form a run starting at the innermost level
    assert_wrap_contig_R4: assert property (@(posedge clk) disable iff (rst)
        (wrap_o & (wrap_o + NUM_LOOPS'(1))) == '0);

    // R5: completion comes with every level wrapped
    assert_done_all_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (&wrap_o));

    // R6: completion holds until start
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        done_o && !start |=> done_o);

    // R7: counters frozen while code runs
    assert_busy_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        busy_o && !start |=> $stable(iter_o));
endmodule

// File: tb/loopseq_top_tb.sv
module loopseq_top_tb;
    localparam int NL = 6;
    localparam int DW = 16;
    localparam int CL = 22;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic step = 1'b0;
    logic [CL*8-1:0]  code_i;
    logic [NL*8-1:0]  loop_desc_i;
    logic [16*DW-1:0] ro_i;
    logic [4*DW-1:0]  rw_o;
    logic [NL*DW-1:0] iter_o;
    logic [NL-1:0]    wrap_o;
    logic             busy_o;
    logic             done_o;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0]    prog [CL];
    logic [7:0]    desc [NL];
    logic [DW-1:0] ro   [16];

    int unsigned   m_cnt [NL];
    logic [DW-1:0] m_rw  [4];
    logic [NL-1:0] m_wrap;
    bit            m_done;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < CL; i++) code_i[i*8 +: 8] = prog[i];
        for (int k = 0; k < NL; k++) loop_desc_i[k*8 +: 8] = desc[k];
        for (int j = 0; j < 16; j++) ro_i[j*DW +: DW] = ro[j];
    end

    loopseq_top #(.NUM_LOOPS(NL), .DATA_W(DW), .CODE_LEN(CL)) u_dut (
        .clk(clk), .rst(rst), .start(start), .step(step),
        .code_i(code_i), .loop_desc_i(loop_desc_i), .ro_i(ro_i),
        .rw_o(rw_o), .iter_o(iter_o), .wrap_o(wrap_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input bit add, input int dst, input bit from_ro, input int src);
        return {add, 2'(dst), from_ro, 4'(src)};
    endfunction

    function automatic int unsigned eff_range(input int k);
        int unsigned r;
        r = ro[desc[k][3:0]];
        return (r == 0) ? 1 : r;
    endfunction

    function automatic int find_level();
        for (int k = 0; k < NL; k++)
            if (m_cnt[k] + 1 < eff_range(k)) return k;
        return -1;
    endfunction

    task automatic model_clear();
        for (int k = 0; k < NL; k++) m_cnt[k] = 0;
        for (int r = 0; r < 4; r++) m_rw[r] = '0;
        m_wrap = '0;
        m_done = 0;
    endtask

    task automatic model_exec(input logic [7:0] u);
        logic [DW-1:0] s;
        s = u[4] ? ro[u[3:0]] : m_rw[u[1:0]];
        if (u[7]) m_rw[u[6:5]] = m_rw[u[6:5]] + s;
        else      m_rw[u[6:5]] = s;
    endtask

    task automatic model_step();
        int lvl;
        int base;
        if (m_done) return;
        lvl = find_level();
        if (lvl < 0) begin
            for (int k = 0; k < NL; k++) m_cnt[k] = 0;
            m_wrap = '1;
            m_done = 1;
            return;
        end
        base = 0;
        m_wrap = '0;
        for (int k = 0; k < lvl; k++) begin
            m_cnt[k] = 0;
            m_wrap[k] = 1'b1;
            base += desc[k][7:4];
        end
        m_cnt[lvl]++;
        for (int j = 0; j < desc[lvl][7:4]; j++)
            model_exec((base + j < CL) ? prog[base + j] : 8'h00);
    endtask

    task automatic compare_all(input string ctx);
        logic [4*DW-1:0]  erw;
        logic [NL*DW-1:0] eit;
        for (int r = 0; r < 4; r++) erw[r*DW +: DW] = m_rw[r];
        for (int k = 0; k < NL; k++) eit[k*DW +: DW] = DW'(m_cnt[k]);
        chk({ctx, " R2 R3 registers"}, rw_o, erw);
        chk({ctx, " R4 counters"}, iter_o, eit);
        chk({ctx, " R4 wrap mask"}, wrap_o, m_wrap);
        chk({ctx, " R5 R6 done"}, done_o, m_done);
    endtask

    task automatic do_step(input bit poke);
        bit exp_busy;
        int lvl;
        lvl = find_level();
        exp_busy = !m_done && (lvl >= 0) && (desc[(lvl < 0) ? 0 : lvl][7:4] != 0);
        @(negedge clk) step = 1'b1;
        @(negedge clk) step = 1'b0;
        chk("R4 R8 busy after accept", busy_o, exp_busy);
        if (poke && busy_o) begin
            step = 1'b1;   // R7: request during a running step
            @(negedge clk) step = 1'b0;
        end
        while (busy_o) @(negedge clk);
        model_step();
        compare_all(poke ? "step+poke R7" : "step");
    endtask

    task automatic check_clear(input string ctx);
        chk({ctx, " R1 registers"}, rw_o, '0);
        chk({ctx, " R1 counters"}, iter_o, '0);
        chk({ctx, " R1 wrap"}, wrap_o, '0);
        chk({ctx, " R1 busy"}, busy_o, 1'b0);
        chk({ctx, " R1 done"}, done_o, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int j = 0; j < 16; j++) ro[j] = '0;
        ro[1] = 16'd3;  ro[2] = 16'd2;  ro[3] = 16'd2;  ro[4] = 16'd2;
        ro[6] = 16'd4;  ro[7] = 16'd3;
        ro[8] = 16'd5;  ro[9] = 16'd100; ro[10] = 16'h7000; ro[11] = 16'd1;
        ro[12] = 16'd0; ro[13] = 16'hFFFF; ro[14] = 16'h1234; ro[15] = 16'h0F0F;

        // Program A: level 3 has a count but no code (R8), level 5 uses an empty range (R3)
        desc[0] = {4'd2, 4'd1};
        desc[1] = {4'd3, 4'd2};
        desc[2] = {4'd4, 4'd3};
        desc[3] = {4'd0, 4'd2};
        desc[4] = {4'd9, 4'd4};
        desc[5] = {4'd4, 4'd0};
        prog[0]  = enc(1, 0, 1, 8);   prog[1]  = enc(1, 1, 1, 11);
        prog[2]  = enc(0, 0, 1, 12);  prog[3]  = enc(1, 2, 1, 9);   prog[4]  = enc(0, 1, 0, 2);
        prog[5]  = enc(1, 3, 1, 10);  prog[6]  = enc(0, 0, 0, 3);   prog[7]  = enc(1, 0, 0, 0);
        prog[8]  = enc(0, 2, 1, 13);
        prog[9]  = enc(1, 2, 1, 11);  prog[10] = enc(1, 3, 0, 3);   prog[11] = enc(1, 1, 0, 2);
        prog[12] = enc(0, 0, 1, 14);  prog[13] = enc(1, 0, 1, 15);  prog[14] = enc(1, 0, 0, 1);
        prog[15] = enc(0, 3, 0, 0);   prog[16] = enc(1, 3, 1, 10);  prog[17] = enc(1, 2, 1, 13);
        prog[18] = enc(0, 0, 1, 13);  prog[19] = enc(0, 1, 1, 13);  prog[20] = enc(0, 2, 1, 13);
        prog[21] = enc(0, 3, 1, 13);

        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_clear("after reset");

        // 3*2*2*2*2 = 48 iterations, the 48th step wraps everything
        for (int s = 0; s < 48; s++) do_step(s % 7 == 3);
        chk("R5 done after full nest", done_o, 1'b1);
        // R6: steps after completion are ignored
        do_step(0);
        do_step(0);

        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        model_clear();
        check_clear("after start");

        // Program B: long level-0 run, level-1 code runs past the last slot (R3)
        desc[0] = {4'd15, 4'd6};
        desc[1] = {4'd10, 4'd7};
        for (int k = 2; k < NL; k++) desc[k] = {4'd0, 4'd0};
        for (int i = 0; i < CL; i++)
            prog[i] = enc(i % 2, i % 4, (i % 3) == 0, (i * 7 + 3) % 16);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        model_clear();
        check_clear("program B start");

        for (int s = 0; s < 12; s++) do_step(1);
        chk("R5 done program B", done_o, 1'b1);
        do_step(1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule